// File: doc/BRIEF.md
# Compensation Filter Mode Selector

This block chooses which compensation-filter preset a digital power-factor control loop applies at any moment. On the voltage side it picks between the normal, slowly sampled voltage filter and a fast voltage filter. The fast filter is used while the output-voltage error lies outside a tolerance band set as a fraction of the reference. On the current side it picks between a low-line and a high-line current filter, based on the RMS line value reported once per half line cycle.

Every change the loop would see as a disturbance is deferred to a zero crossing of the rectified input and qualified by line-cycle counts. Leaving fast mode waits a programmable number of half cycles. A line-range change must persist for four full line cycles. Fast mode that never settles is abandoned after a fixed millisecond timeout. During soft start the fast voltage filter is forced on. The filters themselves live elsewhere. This block only drives their selects and two status flags.

Top module: `filter_mode_sel`

## Requirements
- R1: The error is out of band when |err_code| is strictly greater than ref_code >> (6 - band_sel). So band_sel 0,1,2,3 gives roughly 1.5%, 3%, 6% and 12% of the reference. An error equal to the limit is in band.
- R2: With fast_en high, an out-of-band error moves vfilt_fast from 0 to 1 only in the cycle after a zero_x strobe. If the error returns in band before that strobe, no switch happens.
- R3: In fast mode, once the error is in band, the block counts exit_dly half_cyc strobes and then returns to normal at the next zero_x. With exit_dly 0 it returns at the first zero_x. If the error leaves the band during the wait, the count restarts.
- R4: If fast mode stays out of band for TIMEOUT_MS ms_tick pulses after entry, vfilt_fast drops in the cycle after the last tick and fast_tmo rises. Fast mode cannot be re-entered until the error is back in band, which also clears fast_tmo.
- R5: With fast_en low, out-of-band errors never select the fast filter. Clearing fast_en while in fast mode returns to normal on the next clock.
- R6: While soft_start is high, vfilt_fast is 1 regardless of fast_en and the error.
- R7: fast_flag is 1 exactly when the fast voltage filter is selected (vfilt_fast).
- R8: ifilt_high (0 = low-line filter, 1 = high-line filter, 0 after reset) changes only when two conditions hold. The RMS value sampled at half_cyc must have been beyond the opposite threshold for 8 consecutive half cycles (rms_code > thr_high to go high, rms_code < thr_low to go low). Then the change happens in the cycle after the next zero_x. line_pend is 1 while such a crossing is being counted.
- R9: A value between the thresholds, or equal to the one being crossed, holds the current selection. A half cycle that fails the crossing test clears the count and line_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_code | input | ERR_W | Signed output-voltage error |
| ref_code | input | REF_W | Output-voltage reference |
| fast_en | input | 1 | Allows fast voltage-filter mode |
| band_sel | input | 2 | Tolerance band select |
| exit_dly | input | DLY_W | Half cycles to wait before leaving fast mode |
| rms_code | input | RMS_W | RMS line value, valid at half_cyc |
| thr_high | input | RMS_W | High-line threshold |
| thr_low | input | RMS_W | Low-line threshold |
| half_cyc | input | 1 | Half line cycle strobe |
| zero_x | input | 1 | Rectified-input zero crossing strobe |
| ms_tick | input | 1 | One-millisecond tick |
| soft_start | input | 1 | Soft start in progress |
| vfilt_fast | output | 1 | Fast voltage filter select |
| ifilt_high | output | 1 | High-line current filter select |
| fast_flag | output | 1 | Fast voltage filter in use |
| fast_tmo | output | 1 | Fast mode abandoned on timeout |
| line_pend | output | 1 | Line-range change being confirmed |

## Verification
The band comparison is driven with errors exactly at the limit and one code past it, with both signs and at the narrowest and widest band. This separates a strict from an inclusive compare and catches a wrong shift. Fast-mode entry and exit are driven with zero crossings placed before and after the half-cycle count completes, and with an error that leaves the band mid-wait. These patterns tell apart immediate switching, a mis-counted delay and a delay that fails to restart. The line path is fed values between the thresholds, equal to a threshold, a crossing that falls back after five half cycles and one that persists. Together they distinguish hysteresis, persistence counting, counter clearing and zero-crossing alignment.

// File: rtl/fms_pkg.sv
package fms_pkg;

   typedef enum logic [2:0] {
      FS_NORM,
      FS_ARM,
      FS_FAST,
      FS_EXWAIT,
      FS_EXZX,
      FS_HOLD
   } fast_st_t;

   localparam int unsigned BAND_BASE_SHIFT = 6;

   function automatic logic [2:0] band_shift(input logic [1:0] sel);
      return 3'(BAND_BASE_SHIFT) - {1'b0, sel};
   endfunction

endpackage

// File: rtl/fms_band_cmp.sv
module fms_band_cmp #(
   parameter int unsigned ERR_W   = 12,
   parameter int unsigned REF_W   = 12,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ERR_W-1:0] err,
   input  logic [REF_W-1:0]        vref,
   input  logic [1:0]              band_sel,
   output logic                    out_band
);
   import fms_pkg::*;

   localparam int unsigned MAG_W = ERR_W + 1;
   localparam int unsigned CMP_W = (MAG_W > REF_W) ? MAG_W : REF_W;

   logic signed [MAG_W-1:0] err_ext;
   logic [MAG_W-1:0]        mag;
   logic [REF_W-1:0]        lim;
   logic                    over;

   always_comb begin
      err_ext = {err[ERR_W-1], err};
      mag     = err_ext[MAG_W-1] ? MAG_W'(-err_ext) : MAG_W'(err_ext);
      lim     = vref >> band_shift(band_sel);
      over    = CMP_W'(mag) > CMP_W'(lim);
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_band <= 1'b0;
            else        out_band <= over;
         end
      end else begin : g_comb
         assign out_band = over;
      end
   endgenerate

endmodule

// File: rtl/fms_fast_ctl.sv
module fms_fast_ctl #(
   parameter int unsigned DLY_W      = 3,
   parameter int unsigned TIMEOUT_MS = 630
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_en,
   input  logic             out_band,
   input  logic [DLY_W-1:0] exit_dly,
   input  logic             half_cyc,
   input  logic             zero_x,
   input  logic             ms_tick,
   output logic             fast_on,
   output logic             tmo
);
   import fms_pkg::*;

   localparam int unsigned TMR_W = $clog2(TIMEOUT_MS + 1);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_MS - 1);

   fast_st_t         st;
   logic [TMR_W-1:0] tmr;
   logic [DLY_W:0]   hcnt;
   logic [DLY_W:0]   hcnt_nx;

   assign hcnt_nx = hcnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= FS_NORM;
         tmr  <= '0;
         hcnt <= '0;
      end else if (!fast_en) begin
         st   <= FS_NORM;
         tmr  <= '0;
         hcnt <= '0;
      end else begin
         case (st)
            FS_NORM:   if (out_band) st <= FS_ARM;
            FS_ARM: begin
               if (!out_band)   st <= FS_NORM;
               else if (zero_x) begin
                  st  <= FS_FAST;
                  tmr <= '0;
               end
            end
            FS_FAST: begin
               if (!out_band) begin
                  hcnt <= '0;
                  tmr  <= '0;
                  st   <= (exit_dly == '0) ? FS_EXZX : FS_EXWAIT;
               end else if (ms_tick) begin
                  if (tmr == TMR_LAST) st <= FS_HOLD;
                  else                 tmr <= tmr + 1'b1;
               end
            end
            FS_EXWAIT: begin
               if (out_band) st <= FS_FAST;
               else if (half_cyc) begin
                  hcnt <= hcnt_nx;
                  if (hcnt_nx >= {1'b0, exit_dly}) st <= FS_EXZX;
               end
            end
            FS_EXZX: begin
               if (out_band)    st <= FS_FAST;
               else if (zero_x) st <= FS_NORM;
            end
            FS_HOLD:   if (!out_band) st <= FS_NORM;
            default:   st <= FS_NORM;
         endcase
      end
   end

   assign fast_on = (st == FS_FAST) || (st == FS_EXWAIT) || (st == FS_EXZX);
   assign tmo     = (st == FS_HOLD);

endmodule

// File: rtl/fms_line_ctl.sv
module fms_line_ctl #(
   parameter int unsigned RMS_W    = 11,
   parameter int unsigned LINE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RMS_W-1:0] rms,
   input  logic [RMS_W-1:0] thr_hi,
   input  logic [RMS_W-1:0] thr_lo,
   input  logic             half_cyc,
   input  logic             zero_x,
   output logic             ihigh,
   output logic             pend
);
   localparam int unsigned LINE_HALF = 2 * LINE_CYC;
   localparam int unsigned CNT_W     = $clog2(LINE_HALF + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINE_HALF);

   logic [CNT_W-1:0] cnt;
   logic             flip_req;
   logic             ready;

   assign flip_req = ihigh ? (rms < thr_lo) : (rms > thr_hi);
   assign ready    = (cnt == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ihigh <= 1'b0;
         cnt   <= '0;
      end else if (ready && zero_x) begin
         ihigh <= ~ihigh;
         cnt   <= '0;
      end else if (half_cyc) begin
         if (!flip_req)  cnt <= '0;
         else if (!ready) cnt <= cnt + 1'b1;
      end
   end

   assign pend = (cnt != '0);

endmodule

// File: rtl/filter_mode_sel.sv
module filter_mode_sel #(
   parameter int unsigned ERR_W      = 12,
   parameter int unsigned REF_W      = 12,
   parameter int unsigned RMS_W      = 11,
   parameter int unsigned DLY_W      = 3,
   parameter int unsigned TIMEOUT_MS = 630,
   parameter int unsigned LINE_CYC   = 4,
   parameter bit          REG_CMP    = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ERR_W-1:0] err_code,
   input  logic [REF_W-1:0]        ref_code,
   input  logic                    fast_en,
   input  logic [1:0]              band_sel,
   input  logic [DLY_W-1:0]        exit_dly,
   input  logic [RMS_W-1:0]        rms_code,
   input  logic [RMS_W-1:0]        thr_high,
   input  logic [RMS_W-1:0]        thr_low,
   input  logic                    half_cyc,
   input  logic                    zero_x,
   input  logic                    ms_tick,
   input  logic                    soft_start,
   output logic                    vfilt_fast,
   output logic                    ifilt_high,
   output logic                    fast_flag,
   output logic                    fast_tmo,
   output logic                    line_pend
);

   generate
      if (REF_W < 7) begin : g_bad_ref
         $error("filter_mode_sel: REF_W must allow a shift by 6");
      end
      if (TIMEOUT_MS == 0) begin : g_bad_tmo
         $error("filter_mode_sel: TIMEOUT_MS must be nonzero");
      end
      if (LINE_CYC == 0) begin : g_bad_line
         $error("filter_mode_sel: LINE_CYC must be nonzero");
      end
      if (ERR_W < 2 || DLY_W < 1 || RMS_W < 1) begin : g_bad_w
         $error("filter_mode_sel: width parameter too small");
      end
   endgenerate

   logic out_band;
   logic fast_on;

   fms_band_cmp #(
      .ERR_W  (ERR_W),
      .REF_W  (REF_W),
      .REG_OUT(REG_CMP)
   ) u_band (
      .clk     (clk),
      .rst_n   (rst_n),
      .err     (err_code),
      .vref    (ref_code),
      .band_sel(band_sel),
      .out_band(out_band)
   );

   fms_fast_ctl #(
      .DLY_W     (DLY_W),
      .TIMEOUT_MS(TIMEOUT_MS)
   ) u_fast (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast_en (fast_en),
      .out_band(out_band),
      .exit_dly(exit_dly),
      .half_cyc(half_cyc),
      .zero_x  (zero_x),
      .ms_tick (ms_tick),
      .fast_on (fast_on),
      .tmo     (fast_tmo)
   );

   fms_line_ctl #(
      .RMS_W   (RMS_W),
      .LINE_CYC(LINE_CYC)
   ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .rms     (rms_code),
      .thr_hi  (thr_high),
      .thr_lo  (thr_low),
      .half_cyc(half_cyc),
      .zero_x  (zero_x),
      .ihigh   (ifilt_high),
      .pend    (line_pend)
   );

   assign vfilt_fast = fast_on | soft_start;
   assign fast_flag  = fast_on | soft_start;

endmodule

// File: rtl/fms_checker.sv
module fms_checker (
   input logic clk,
   input logic rst_n,
   input logic fast_en,
   input logic zero_x,
   input logic soft_start,
   input logic vfilt_fast,
   input logic ifilt_high,
   input logic fast_flag,
   input logic fast_tmo
);

   // R2: a rise of the fast select not caused by soft start follows a zero crossing
   assert_entry_on_zx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_start && !$past(soft_start) && !$past(vfilt_fast) && vfilt_fast) |-> $past(zero_x));

   // R4: a timed-out fast mode does not keep the fast filter
   assert_tmo_exits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_tmo && !soft_start) |-> !vfilt_fast);

   // R5: fast mode disabled keeps the normal filter
   assert_disabled_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_en && !$past(fast_en) && !soft_start) |-> !vfilt_fast);

   // R6: soft start forces the fast voltage filter
   assert_soft_start_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_start |-> vfilt_fast);

   // R7: status flag tracks the voltage filter select
   assert_flag_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fast_flag == vfilt_fast);

   // R8: current filter select changes only after a zero crossing
   assert_line_on_zx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ifilt_high) |-> $past(zero_x));

endmodule

bind filter_mode_sel fms_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fast_en   (fast_en),
   .zero_x    (zero_x),
   .soft_start(soft_start),
   .vfilt_fast(vfilt_fast),
   .ifilt_high(ifilt_high),
   .fast_flag (fast_flag),
   .fast_tmo  (fast_tmo)
);

// File: tb/filter_mode_sel_test.sv
module filter_mode_sel_test;

   localparam int TMO_MS = 630;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [11:0] err_code = '0;
   logic [11:0]        ref_code = 12'd1024;
   logic               fast_en = 1'b1;
   logic [1:0]         band_sel = 2'd0;
   logic [2:0]         exit_dly = 3'd0;
   logic [10:0]        rms_code = 11'd550;
   logic [10:0]        thr_high = 11'd600;
   logic [10:0]        thr_low = 11'd500;
   logic               half_cyc = 1'b0;
   logic               zero_x = 1'b0;
   logic               ms_tick = 1'b0;
   logic               soft_start = 1'b0;
   logic               vfilt_fast, ifilt_high, fast_flag, fast_tmo, line_pend;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   filter_mode_sel uut (
      .clk(clk), .rst_n(rst_n), .err_code(err_code), .ref_code(ref_code),
      .fast_en(fast_en), .band_sel(band_sel), .exit_dly(exit_dly),
      .rms_code(rms_code), .thr_high(thr_high), .thr_low(thr_low),
      .half_cyc(half_cyc), .zero_x(zero_x), .ms_tick(ms_tick),
      .soft_start(soft_start), .vfilt_fast(vfilt_fast), .ifilt_high(ifilt_high),
      .fast_flag(fast_flag), .fast_tmo(fast_tmo), .line_pend(line_pend)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_zx();
      zero_x = 1'b1; step(1); zero_x = 1'b0;
   endtask

   task automatic pulse_hc();
      half_cyc = 1'b1; step(1); half_cyc = 1'b0;
   endtask

   task automatic pulse_ms();
      ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1);
   endtask

   task automatic t_reset();
      chk("R7 reset vfilt_fast", vfilt_fast, 1'b0);
      chk("R8 reset ifilt_high", ifilt_high, 1'b0);
      chk("R7 reset fast_flag", fast_flag, 1'b0);
      chk("R4 reset fast_tmo", fast_tmo, 1'b0);
      chk("R9 reset line_pend", line_pend, 1'b0);
   endtask

   task automatic t_band();
      band_sel = 2'd0; exit_dly = 3'd0;
      err_code = 12'sd16; step(1); pulse_zx();
      chk("R1 err at limit sel0 stays normal", vfilt_fast, 1'b0);
      err_code = 12'sd17; step(2);
      chk("R2 no switch before zero crossing", vfilt_fast, 1'b0);
      pulse_zx();
      chk("R1 err past limit sel0 enters fast", vfilt_fast, 1'b1);
      chk("R7 flag follows fast select", fast_flag, 1'b1);
      err_code = 12'sd0; step(1); pulse_zx();
      chk("R3 zero delay leaves at zero crossing", vfilt_fast, 1'b0);
      band_sel = 2'd3;
      err_code = -12'sd128; step(1); pulse_zx();
      chk("R1 negative err at limit sel3 stays normal", vfilt_fast, 1'b0);
      err_code = -12'sd129; step(1); pulse_zx();
      chk("R1 negative err past limit sel3 enters fast", vfilt_fast, 1'b1);
      err_code = 12'sd0; step(1); pulse_zx();
      err_code = 12'sd200; step(2); err_code = 12'sd0; step(1); pulse_zx();
      chk("R2 in-band before zero crossing cancels entry", vfilt_fast, 1'b0);
      band_sel = 2'd0;
   endtask

   task automatic t_exit();
      exit_dly = 3'd2;
      err_code = 12'sd200; step(1); pulse_zx();
      chk("R3 fast entered", vfilt_fast, 1'b1);
      err_code = 12'sd0; step(1); pulse_zx();
      chk("R3 zero crossing before delay keeps fast", vfilt_fast, 1'b1);
      pulse_hc(); pulse_hc();
      chk("R3 delay done still waits for zero crossing", vfilt_fast, 1'b1);
      pulse_zx();
      chk("R3 exit after delay and zero crossing", vfilt_fast, 1'b0);
      err_code = 12'sd200; step(1); pulse_zx();
      err_code = 12'sd0; step(1); pulse_hc();
      err_code = 12'sd200; step(2);
      err_code = 12'sd0; step(1); pulse_hc(); pulse_zx();
      chk("R3 count restarts after leaving band", vfilt_fast, 1'b1);
      pulse_hc(); pulse_zx();
      chk("R3 exit after restarted count", vfilt_fast, 1'b0);
      exit_dly = 3'd0;
   endtask

   task automatic t_timeout();
      err_code = 12'sd200; step(1); pulse_zx();
      for (int i = 0; i < TMO_MS - 1; i++) pulse_ms();
      chk("R4 fast held before timeout", vfilt_fast, 1'b1);
      pulse_ms();
      chk("R4 timeout returns to normal", vfilt_fast, 1'b0);
      chk("R4 timeout flag set", fast_tmo, 1'b1);
      pulse_zx();
      chk("R4 no re-entry while still out of band", vfilt_fast, 1'b0);
      err_code = 12'sd0; step(2);
      chk("R4 timeout flag clears in band", fast_tmo, 1'b0);
   endtask

   task automatic t_enable();
      fast_en = 1'b0; err_code = 12'sd200; step(1); pulse_zx();
      chk("R5 disabled ignores out-of-band error", vfilt_fast, 1'b0);
      fast_en = 1'b1; step(1); pulse_zx();
      chk("R5 enabled enters fast", vfilt_fast, 1'b1);
      fast_en = 1'b0; step(1);
      chk("R5 disable leaves fast next clock", vfilt_fast, 1'b0);
      err_code = 12'sd0; step(1); fast_en = 1'b1; step(1);
   endtask

   task automatic t_soft();
      fast_en = 1'b0; soft_start = 1'b1; step(1);
      chk("R6 soft start forces fast filter", vfilt_fast, 1'b1);
      chk("R7 flag set during soft start", fast_flag, 1'b1);
      soft_start = 1'b0; step(1);
      chk("R6 soft start released", vfilt_fast, 1'b0);
      fast_en = 1'b1; step(1);
   endtask

   task automatic t_line();
      rms_code = 11'd550;
      for (int i = 0; i < 10; i++) pulse_hc();
      pulse_zx();
      chk("R9 between thresholds holds low", ifilt_high, 1'b0);
      chk("R9 between thresholds not pending", line_pend, 1'b0);
      rms_code = 11'd600;
      for (int i = 0; i < 8; i++) pulse_hc();
      pulse_zx();
      chk("R9 equal to high threshold holds low", ifilt_high, 1'b0);
      rms_code = 11'd700;
      for (int i = 0; i < 7; i++) pulse_hc();
      chk("R8 pending during confirmation", line_pend, 1'b1);
      pulse_hc();
      chk("R8 confirmed but waits zero crossing", ifilt_high, 1'b0);
      pulse_zx();
      chk("R8 switch to high line at zero crossing", ifilt_high, 1'b1);
      chk("R8 pending cleared after switch", line_pend, 1'b0);
      rms_code = 11'd400;
      for (int i = 0; i < 5; i++) pulse_hc();
      rms_code = 11'd550; pulse_hc();
      chk("R9 fall back clears pending", line_pend, 1'b0);
      rms_code = 11'd400;
      for (int i = 0; i < 7; i++) pulse_hc();
      pulse_zx();
      chk("R9 restarted count not yet confirmed", ifilt_high, 1'b1);
      pulse_hc(); pulse_zx();
      chk("R8 switch to low line", ifilt_high, 1'b0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_band();
      t_exit();
      t_timeout();
      t_enable();
      t_soft();
      t_line();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule